// File: doc/BRIEF.md
# Dual-Window Scratch RAM Decoder

This block places one small on-chip RAM of 4 KiB into the address space twice: once for the instruction-fetch side and once for the data side. Each side has its own base register and its own control register, both written and read through a simple register port addressed by a register number. A base register keeps only the high address bits that select a 64 MiB-aligned region. A control register keeps two bits, the top one of which turns its window on.

Each side compares its incoming address against its own base and enable and, on a match, raises a hit and presents the RAM word index taken from the low address bits. The instruction side reads only; the data side reads and writes. Because both windows lead to the same storage, a word written through the data window is then fetched unchanged through the instruction window. Both windows may sit on the same base; each side still decodes on its own, and the storage is neither split nor duplicated.

Top module: `ocm_dual_window`

## Requirements
- R1: Register number 0x018 selects the instruction base, 0x019 the instruction control, 0x01A the data base and 0x01B the data control; a read strobe returns the stored value on `reg_rdata` in the cycle after the strobe.
- R2: A base register stores only bits 31:26 of the written word; every other bit reads as zero.
- R3: A control register stores only bits 31:30 of the written word; bit 31 enables its window and bit 30 alone leaves the window off.
- R4: After reset all four registers read zero and neither side hits, even for address 0.
- R5: A side hits when its enable is set, address bits 31:26 equal its base bits 31:26, and address bits 25:12 are zero.
- R6: The word index of a side is address bits 11:2, and RAM read data for a hit access appears in the cycle after the access.
- R7: A word written through the data window is returned by a later fetch of the same word index through the instruction window.
- R8: With both windows enabled at the same base, an address in that region hits on both sides with the same index, and a data write there is fetched back from the instruction side.
- R9: Writing a data-side register leaves both instruction-side registers unchanged, and writing an instruction-side register leaves both data-side registers unchanged.
- R10: A read of any register number other than 0x018 to 0x01B returns zero, and a write to such a number changes no register.
- R11: A data write whose address misses the data window leaves the storage unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 10 | Register number |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_rd` |
| if_req | input | 1 | Instruction fetch request |
| if_addr | input | 32 | Instruction fetch address |
| if_hit | output | 1 | Instruction address falls in the instruction window |
| if_index | output | 10 | RAM word index of the instruction address |
| if_rdata | output | 32 | Fetched word, one cycle after a hitting request |
| dm_req | input | 1 | Data access request |
| dm_we | input | 1 | Data access is a write |
| dm_addr | input | 32 | Data access address |
| dm_wdata | input | 32 | Data write word |
| dm_hit | output | 1 | Data address falls in the data window |
| dm_index | output | 10 | RAM word index of the data address |
| dm_rdata | output | 32 | Read word, one cycle after a hitting data read |

## Verification
The assertions take for granted that `reg_rd` and `reg_wr` are never raised together and that every access is a full aligned word, so the low two address bits carry no meaning. The read-mask properties also rely on the register port being idle or re-strobed in the cycle after a read, since `reg_rdata` is only defined for the cycle that follows the strobe. The bench drives each strobe for exactly one cycle, never overlaps a read with a write, and keeps its RAM addresses word-aligned.

// File: rtl/ocmw_pkg.sv
package ocmw_pkg;

  localparam int DW = 32;

  typedef logic [DW-1:0] word_t;

  // Position of each register slot relative to the first register number.
  typedef enum logic [1:0] {
    SLOT_IBASE = 2'd0,
    SLOT_ICTRL = 2'd1,
    SLOT_DBASE = 2'd2,
    SLOT_DCTRL = 2'd3
  } slot_e;

  // Word with its top n bits set.
  function automatic word_t keep_top(input int n);
    word_t m;
    m = '0;
    for (int b = 0; b < DW; b++) begin
      if (b >= DW - n) m[b] = 1'b1;
    end
    return m;
  endfunction

  // Window match: enable set, region bits equal the base, span bits zero.
  function automatic logic window_hit(input logic en, input word_t base,
                                      input word_t addr, input int base_lsb,
                                      input int span_lsb);
    word_t region_m;
    word_t span_m;
    region_m = keep_top(DW - base_lsb);
    span_m   = keep_top(DW - span_lsb) & ~region_m;
    return en && ((addr & region_m) == (base & region_m))
              && ((addr & span_m) == '0);
  endfunction

endpackage

// File: rtl/ocmw_regs.sv
module ocmw_regs
  import ocmw_pkg::*;
#(
  parameter int             SEL_W     = 10,
  parameter logic [SEL_W-1:0] FIRST_SEL = 10'h018,
  parameter int             BASE_LSB  = 26,
  parameter int             CTRL_KEEP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd,
  input  logic             wr,
  input  logic [SEL_W-1:0] sel,
  input  word_t            wdata,
  output word_t            rdata,
  output word_t            ibase_q,
  output word_t            ictrl_q,
  output word_t            dbase_q,
  output word_t            dctrl_q
);

  localparam int    NSLOT     = 4;
  localparam word_t BASE_MASK = keep_top(DW - BASE_LSB);
  localparam word_t CTRL_MASK = keep_top(CTRL_KEEP);

  logic [SEL_W-1:0] offset;
  logic             in_range;
  logic [1:0]       slot;
  word_t            slot_val [NSLOT];

  assign offset   = sel - FIRST_SEL;
  assign in_range = (sel >= FIRST_SEL) && (offset < SEL_W'(NSLOT));
  assign slot     = offset[1:0];

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    // Even slots hold a base, odd slots hold a control word.
    localparam word_t MASK = ((s % 2) == 0) ? BASE_MASK : CTRL_MASK;
    word_t q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= '0;
      end else if (wr && in_range && (slot == 2'(s))) begin
        q <= wdata & MASK;
      end
    end
    assign slot_val[s] = q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd) begin
      rdata <= in_range ? slot_val[slot] : '0;
    end
  end

  assign ibase_q = slot_val[SLOT_IBASE];
  assign ictrl_q = slot_val[SLOT_ICTRL];
  assign dbase_q = slot_val[SLOT_DBASE];
  assign dctrl_q = slot_val[SLOT_DCTRL];

endmodule

// File: rtl/ocmw_window.sv
module ocmw_window
  import ocmw_pkg::*;
#(
  parameter int BASE_LSB = 26,
  parameter int IDX_W    = 10
) (
  input  word_t            base_q,
  input  word_t            ctrl_q,
  input  word_t            addr,
  output logic             hit,
  output logic [IDX_W-1:0] index
);

  // Span above the word index must be zero; two byte-offset bits below it.
  localparam int SPAN_LSB = IDX_W + 2;

  assign hit   = window_hit(ctrl_q[DW-1], base_q, addr, BASE_LSB, SPAN_LSB);
  assign index = addr[SPAN_LSB-1:2];

endmodule

// File: rtl/ocmw_ram.sv
module ocmw_ram
  import ocmw_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             a_en,
  input  logic [IDX_W-1:0] a_idx,
  output word_t            a_rdata,
  input  logic             b_en,
  input  logic             b_we,
  input  logic [IDX_W-1:0] b_idx,
  input  word_t            b_wdata,
  output word_t            b_rdata
);

  localparam int DEPTH = 1 << IDX_W;

  word_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (b_en && b_we) mem[b_idx] <= b_wdata;
  end

  always_ff @(posedge clk) begin
    if (a_en) a_rdata <= mem[a_idx];
  end

  always_ff @(posedge clk) begin
    if (b_en && !b_we) b_rdata <= mem[b_idx];
  end

endmodule

// File: rtl/ocm_dual_window.sv
module ocm_dual_window
  import ocmw_pkg::*;
#(
  parameter int               SEL_W     = 10,
  parameter logic [SEL_W-1:0] FIRST_SEL = 10'h018,
  parameter int               BASE_LSB  = 26,
  parameter int               RAM_BYTES = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_rd,
  input  logic             reg_wr,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             if_req,
  input  logic [31:0]      if_addr,
  output logic             if_hit,
  output logic [9:0]       if_index,
  output logic [31:0]      if_rdata,
  input  logic             dm_req,
  input  logic             dm_we,
  input  logic [31:0]      dm_addr,
  input  logic [31:0]      dm_wdata,
  output logic             dm_hit,
  output logic [9:0]       dm_index,
  output logic [31:0]      dm_rdata
);

  localparam int IDX_W     = $clog2(RAM_BYTES / 4);
  localparam int CTRL_KEEP = 2;
  localparam int NSIDE     = 2;  // 0: instruction, 1: data

  word_t ibase_q, ictrl_q, dbase_q, dctrl_q;

  // Named per-side decode results, visible to the checker.
  word_t            side_base [NSIDE];
  word_t            side_ctrl [NSIDE];
  word_t            side_addr [NSIDE];
  logic             side_hit  [NSIDE];
  logic [IDX_W-1:0] side_idx  [NSIDE];
  logic             ifetch_go;
  logic             data_go;

  ocmw_regs #(
    .SEL_W    (SEL_W),
    .FIRST_SEL(FIRST_SEL),
    .BASE_LSB (BASE_LSB),
    .CTRL_KEEP(CTRL_KEEP)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd     (reg_rd),
    .wr     (reg_wr),
    .sel    (reg_sel),
    .wdata  (reg_wdata),
    .rdata  (reg_rdata),
    .ibase_q(ibase_q),
    .ictrl_q(ictrl_q),
    .dbase_q(dbase_q),
    .dctrl_q(dctrl_q)
  );

  assign side_base[0] = ibase_q;
  assign side_ctrl[0] = ictrl_q;
  assign side_addr[0] = if_addr;
  assign side_base[1] = dbase_q;
  assign side_ctrl[1] = dctrl_q;
  assign side_addr[1] = dm_addr;

  for (genvar k = 0; k < NSIDE; k++) begin : g_side
    ocmw_window #(
      .BASE_LSB(BASE_LSB),
      .IDX_W   (IDX_W)
    ) u_win (
      .base_q(side_base[k]),
      .ctrl_q(side_ctrl[k]),
      .addr  (side_addr[k]),
      .hit   (side_hit[k]),
      .index (side_idx[k])
    );
  end

  assign if_hit   = side_hit[0];
  assign dm_hit   = side_hit[1];
  assign if_index = 10'(side_idx[0]);
  assign dm_index = 10'(side_idx[1]);

  assign ifetch_go = if_req && side_hit[0];
  assign data_go   = dm_req && side_hit[1];

  ocmw_ram #(
    .IDX_W(IDX_W)
  ) u_ram (
    .clk    (clk),
    .a_en   (ifetch_go),
    .a_idx  (side_idx[0]),
    .a_rdata(if_rdata),
    .b_en   (data_go),
    .b_we   (dm_we),
    .b_idx  (side_idx[1]),
    .b_wdata(dm_wdata),
    .b_rdata(dm_rdata)
  );

endmodule

// File: rtl/ocmw_checker.sv
module ocmw_checker #(
  parameter int               SEL_W     = 10,
  parameter logic [SEL_W-1:0] FIRST_SEL = 10'h018,
  parameter int               BASE_LSB  = 26
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_rd,
  input logic             reg_wr,
  input logic [SEL_W-1:0] reg_sel,
  input logic [31:0]      reg_rdata,
  input logic [31:0]      if_addr,
  input logic             if_hit,
  input logic [31:0]      dm_addr,
  input logic             dm_hit,
  input logic [31:0]      ibase_q,
  input logic [31:0]      ictrl_q,
  input logic [31:0]      dbase_q,
  input logic [31:0]      dctrl_q
);

  logic sel_ibase, sel_ictrl, sel_dbase, sel_dctrl, sel_known;
  assign sel_ibase = (reg_sel == FIRST_SEL);
  assign sel_ictrl = (reg_sel == FIRST_SEL + SEL_W'(1));
  assign sel_dbase = (reg_sel == FIRST_SEL + SEL_W'(2));
  assign sel_dctrl = (reg_sel == FIRST_SEL + SEL_W'(3));
  assign sel_known = sel_ibase || sel_ictrl || sel_dbase || sel_dctrl;

  p_base_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && (sel_ibase || sel_dbase) |=> reg_rdata[BASE_LSB-1:0] == '0);

  p_ctrl_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && (sel_ictrl || sel_dctrl) |=> reg_rdata[29:0] == '0);

  p_unknown_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && !sel_known |=> reg_rdata == '0);

  p_if_hit_rule_r5: assert property (@(posedge clk) disable iff (!rst_n)
    if_hit |-> ictrl_q[31] && (if_addr[25:12] == '0)
               && (if_addr[31:BASE_LSB] == ibase_q[31:BASE_LSB]));

  p_dm_hit_rule_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dm_hit |-> dctrl_q[31] && (dm_addr[25:12] == '0)
               && (dm_addr[31:BASE_LSB] == dbase_q[31:BASE_LSB]));

  p_data_write_isolated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && (sel_dbase || sel_dctrl) |=> $stable(ibase_q) && $stable(ictrl_q));

  p_instr_write_isolated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && (sel_ibase || sel_ictrl) |=> $stable(dbase_q) && $stable(dctrl_q));

  p_shared_base_r8: assert property (@(posedge clk) disable iff (!rst_n)
    if_hit && dctrl_q[31] && (dbase_q == ibase_q) && (dm_addr == if_addr) |-> dm_hit);

endmodule

bind ocm_dual_window ocmw_checker #(
  .SEL_W    (SEL_W),
  .FIRST_SEL(FIRST_SEL),
  .BASE_LSB (BASE_LSB)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_rd   (reg_rd),
  .reg_wr   (reg_wr),
  .reg_sel  (reg_sel),
  .reg_rdata(reg_rdata),
  .if_addr  (if_addr),
  .if_hit   (if_hit),
  .dm_addr  (dm_addr),
  .dm_hit   (dm_hit),
  .ibase_q  (ibase_q),
  .ictrl_q  (ictrl_q),
  .dbase_q  (dbase_q),
  .dctrl_q  (dctrl_q)
);

// File: tb/ocm_dual_window_bench.sv
module ocm_dual_window_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_rd = 1'b0, reg_wr = 1'b0;
  logic [9:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        if_req = 1'b0;
  logic [31:0] if_addr = '0, if_rdata;
  logic        if_hit;
  logic [9:0]  if_index;
  logic        dm_req = 1'b0, dm_we = 1'b0;
  logic [31:0] dm_addr = '0, dm_wdata = '0, dm_rdata;
  logic        dm_hit;
  logic [9:0]  dm_index;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  localparam logic [9:0] S_IBASE = 10'h018;
  localparam logic [9:0] S_ICTRL = 10'h019;
  localparam logic [9:0] S_DBASE = 10'h01A;
  localparam logic [9:0] S_DCTRL = 10'h01B;

  always #5 clk = ~clk;

  ocm_dual_window u_ocm_dual_window (
    .clk(clk), .rst_n(rst_n),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .if_req(if_req), .if_addr(if_addr), .if_hit(if_hit),
    .if_index(if_index), .if_rdata(if_rdata),
    .dm_req(dm_req), .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata),
    .dm_hit(dm_hit), .dm_index(dm_index), .dm_rdata(dm_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [9:0] s, input logic [31:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [9:0] s, output logic [31:0] v);
    @(negedge clk);
    reg_rd = 1'b1; reg_sel = s;
    @(negedge clk);
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  task automatic probe(input logic [31:0] ia, input logic [31:0] da);
    @(negedge clk);
    if_addr = ia; dm_addr = da;
    #1;
  endtask

  task automatic data_write(input logic [31:0] a, input logic [31:0] v);
    @(negedge clk);
    dm_req = 1'b1; dm_we = 1'b1; dm_addr = a; dm_wdata = v;
    @(negedge clk);
    dm_req = 1'b0; dm_we = 1'b0;
  endtask

  task automatic data_read(input logic [31:0] a, output logic [31:0] v);
    @(negedge clk);
    dm_req = 1'b1; dm_addr = a;
    @(negedge clk);
    dm_req = 1'b0;
    v = dm_rdata;
  endtask

  task automatic fetch(input logic [31:0] a, output logic [31:0] v);
    @(negedge clk);
    if_req = 1'b1; if_addr = a;
    @(negedge clk);
    if_req = 1'b0;
    v = if_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    reg_read(S_IBASE, v); chk("R4 R1 ibase after reset", v, 32'h0);
    reg_read(S_ICTRL, v); chk("R4 ictrl after reset", v, 32'h0);
    reg_read(S_DBASE, v); chk("R4 dbase after reset", v, 32'h0);
    reg_read(S_DCTRL, v); chk("R4 dctrl after reset", v, 32'h0);
    probe(32'h0, 32'h0);
    chk("R4 no instruction hit at 0", {31'h0, if_hit}, 32'h0);
    chk("R4 no data hit at 0", {31'h0, dm_hit}, 32'h0);
  endtask

  task automatic t_masks;
    logic [31:0] v;
    reg_write(S_IBASE, 32'hFFFF_FFFF);
    reg_read(S_IBASE, v); chk("R2 R1 ibase mask", v, 32'hFC00_0000);
    reg_write(S_ICTRL, 32'hFFFF_FFFF);
    reg_read(S_ICTRL, v); chk("R3 R1 ictrl mask", v, 32'hC000_0000);
    reg_write(S_DBASE, 32'h1234_5678);
    reg_read(S_DBASE, v); chk("R2 dbase mask", v, 32'h1000_0000);
    reg_write(S_DCTRL, 32'h7FFF_FFFF);
    reg_read(S_DCTRL, v); chk("R3 dctrl keeps bit30 only", v, 32'h4000_0000);
    probe(32'h0, 32'h1000_0000);
    chk("R3 bit30 alone leaves data window off", {31'h0, dm_hit}, 32'h0);
  endtask

  task automatic t_isolation;
    logic [31:0] v;
    reg_read(S_IBASE, v); chk("R9 ibase kept across data writes", v, 32'hFC00_0000);
    reg_read(S_ICTRL, v); chk("R9 ictrl kept across data writes", v, 32'hC000_0000);
    reg_write(S_ICTRL, 32'h0);
    reg_write(S_IBASE, 32'h0400_0000);
    reg_read(S_DCTRL, v); chk("R9 dctrl kept across instr writes", v, 32'h4000_0000);
    reg_read(S_DBASE, v); chk("R9 dbase kept across instr writes", v, 32'h1000_0000);
  endtask

  task automatic t_unknown;
    logic [31:0] v;
    reg_write(10'h017, 32'hFFFF_FFFF);
    reg_write(10'h01C, 32'hFFFF_FFFF);
    reg_read(10'h017, v); chk("R10 read below range", v, 32'h0);
    reg_read(10'h01C, v); chk("R10 read above range", v, 32'h0);
    reg_read(S_IBASE, v); chk("R10 ibase unchanged", v, 32'h0400_0000);
    reg_read(S_ICTRL, v); chk("R10 ictrl unchanged", v, 32'h0);
    reg_read(S_DBASE, v); chk("R10 dbase unchanged", v, 32'h1000_0000);
    reg_read(S_DCTRL, v); chk("R10 dctrl unchanged", v, 32'h4000_0000);
  endtask

  task automatic t_hit;
    reg_write(S_ICTRL, 32'h8000_0000);
    probe(32'h0400_0FFC, 32'h0);
    chk("R5 top word hits", {31'h0, if_hit}, 32'h1);
    chk("R6 top word index", {22'h0, if_index}, 32'h3FF);
    probe(32'h0400_1000, 32'h0);
    chk("R5 span bit set misses", {31'h0, if_hit}, 32'h0);
    probe(32'h0800_0000, 32'h0);
    chk("R5 other region misses", {31'h0, if_hit}, 32'h0);
    probe(32'h0400_0124, 32'h0);
    chk("R6 index from bits 11:2", {22'h0, if_index}, 32'h049);
  endtask

  task automatic t_alias;
    logic [31:0] v;
    reg_write(S_DBASE, 32'h2000_0000);
    reg_write(S_DCTRL, 32'h8000_0000);
    data_write(32'h2000_0010, 32'hA5A5_1234);
    data_read(32'h2000_0010, v); chk("R6 data read back", v, 32'hA5A5_1234);
    fetch(32'h0400_0010, v); chk("R7 fetch sees data write", v, 32'hA5A5_1234);
    data_write(32'h2000_1010, 32'hDEAD_BEEF);
    fetch(32'h0400_0010, v); chk("R11 miss write leaves storage", v, 32'hA5A5_1234);
    data_write(32'h3000_0010, 32'hDEAD_BEEF);
    data_read(32'h2000_0010, v); chk("R11 other region write ignored", v, 32'hA5A5_1234);
  endtask

  task automatic t_same_base;
    logic [31:0] v;
    reg_write(S_DBASE, 32'h0400_0000);
    probe(32'h0400_0020, 32'h0400_0020);
    chk("R8 instruction side hits", {31'h0, if_hit}, 32'h1);
    chk("R8 data side hits", {31'h0, dm_hit}, 32'h1);
    chk("R8 same index", {22'h0, dm_index}, {22'h0, if_index});
    data_write(32'h0400_0020, 32'h0BAD_F00D);
    fetch(32'h0400_0020, v); chk("R8 shared word fetched", v, 32'h0BAD_F00D);
    fetch(32'h0400_0010, v); chk("R8 earlier word intact", v, 32'hA5A5_1234);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_masks();
    t_isolation();
    t_unknown();
    t_hit();
    t_alias();
    t_same_base();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

endmodule